// File: doc/BRIEF.md
# Flat-Table Address Translation Unit

This block sits between one bus master and the memory system and turns the master's virtual addresses into physical ones. Memory is cut into 4 KiB pages. The low 12 bits of an address are the offset inside a page and pass through unchanged. The upper bits form the virtual page number (VPN). Translation uses a single linear table in external memory. Each 32-bit word of that table holds the physical page number (PPN) for one virtual page of a contiguous window. A four-entry translation cache keeps recent results, so repeated accesses do not have to read the table again.

Software programs the block through a small 32-bit register port. It sets the table base page, the first VPN of the window, the window span and two fallback pages, one for reads and one for writes. The master issues one request at a time on a valid/ready port and gets back a physical address. When a table entry is needed, the block issues a single read on its memory port and waits for the data. An access outside the window, or one whose entry reads as zero, is not aborted. It is steered to the fallback page for its direction and flagged as a fault. The first such fault is latched in a status register that software can inspect.

Top module: `ftlb_iommu`

## Requirements
- R1: After reset, register 0x00 reads 0x0000_0100 (layout identifier 1 in bits 15:8), and the fault status register (0x0C) reads 0.
- R2: When control bit 0 (enable) is 0, or control bit 4 (bypass) is 1, a request returns rsp_pa equal to req_va with rsp_fault 0. The response comes one cycle after acceptance, and no memory read is issued.
- R3: With translation active, a VPN below the window start (0x1C) or above start plus span (0x20, last page inclusive) faults without a memory read. Its response comes one cycle after acceptance, with the PPN taken from 0x14 for reads or 0x18 for writes.
- R4: A table read is issued at byte address (base PPN at 0x10 << 12) + (VPN − window start) × 4. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen.
- R5: A nonzero entry yields rsp_pa = {entry[19:0], page offset} with rsp_fault 0. The response comes the cycle after mem_rsp_valid, which is three cycles after acceptance when the memory accepts after one wait cycle and answers on the next cycle.
- R6: An all-zero entry makes the access fault to the fallback page of its direction. Such an entry is never cached, so a repeat access reads the table again.
- R7: A request whose VPN is in the cache responds one cycle after acceptance, with no memory read.
- R8: The cache holds four pages, at most one of which can match a given VPN. Fills go to the slots in a rotating order 0,1,2,3,0,…, and a new fill overwrites the oldest slot.
- R9: A write of any value to 0x08 invalidates every cache entry. A table read that is in flight while this write happens still answers the master, but its result is not cached.
- R10: Fault status (0x0C) holds a valid flag in bit 31, the direction (1 = write) in bit 30 and the VPN in bits 19:0. Only the first fault after a clear is captured. A write with bit 31 set clears the register, and a write with bit 31 clear leaves it unchanged.
- R11: Only one request is outstanding: req_ready stays 0 from acceptance until the cycle after the response.
- R12: Control (0x04) reads back only bits 0, 1 and 4, and every other bit reads as 0. Bit 1 is stored but has no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on cfg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Access was steered to a fallback page |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the table read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
Every result arrives at a fixed number of cycles after acceptance. A response without a table read (pass-through, window fault or cache hit) is due one cycle after acceptance. A response that needs a table read is due three cycles after acceptance, given the bench memory's one wait cycle and its answer on the following cycle. The bench drives and samples on falling edges and counts the falling edges from acceptance to rsp_valid. It compares that count with the expected latency, and it compares the change in memory reads with zero or one. Cache residency and replacement order are therefore checked through latency and read counts alone. Fault status and register readback are sampled at least one full cycle after the response that changes them.

// File: rtl/ftlb_pkg.sv
package ftlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xl_state_e;

    // register byte offsets; software depends on these positions
    localparam logic [5:0] RA_VERSION = 6'h00;
    localparam logic [5:0] RA_CONFIG  = 6'h04;
    localparam logic [5:0] RA_FLUSH   = 6'h08;
    localparam logic [5:0] RA_FSTAT   = 6'h0C;
    localparam logic [5:0] RA_TBASE   = 6'h10;
    localparam logic [5:0] RA_DFLT_RD = 6'h14;
    localparam logic [5:0] RA_DFLT_WR = 6'h18;
    localparam logic [5:0] RA_WIN_LO  = 6'h1C;
    localparam logic [5:0] RA_WIN_SPN = 6'h20;

    // control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_GATE = 1;
    localparam int CB_BYP  = 4;

    localparam logic [7:0] LAYOUT_ID = 8'd1;

endpackage

// File: rtl/ftlb_regs.sv
module ftlb_regs
    import ftlb_pkg::*;
#(
    parameter int PG_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [5:0]      addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic            fault_set,
    input  logic [PG_W-1:0] fault_vpn,
    input  logic            fault_wr,
    output logic            xl_en,
    output logic            xl_byp,
    output logic            flush,
    output logic [PG_W-1:0] tbase,
    output logic [PG_W-1:0] dflt_rd,
    output logic [PG_W-1:0] dflt_wr,
    output logic [PG_W-1:0] win_lo,
    output logic [PG_W-1:0] win_span
);

    typedef struct packed {
        logic            en;
        logic            gate;
        logic            byp;
        logic [PG_W-1:0] tbase;
        logic [PG_W-1:0] dflt_rd;
        logic [PG_W-1:0] dflt_wr;
        logic [PG_W-1:0] win_lo;
        logic [PG_W-1:0] win_span;
        logic            fs_v;
        logic            fs_w;
        logic [PG_W-1:0] fs_vpn;
    } regs_t;

    regs_t r_q, r_d;
    logic  unused_bits;

    assign unused_bits = ^wdata;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                RA_CONFIG: begin
                    r_d.en   = wdata[CB_EN];
                    r_d.gate = wdata[CB_GATE];
                    r_d.byp  = wdata[CB_BYP];
                end
                RA_FSTAT: begin
                    if (wdata[31]) begin
                        r_d.fs_v   = 1'b0;
                        r_d.fs_w   = 1'b0;
                        r_d.fs_vpn = '0;
                    end
                end
                RA_TBASE:   r_d.tbase    = wdata[PG_W-1:0];
                RA_DFLT_RD: r_d.dflt_rd  = wdata[PG_W-1:0];
                RA_DFLT_WR: r_d.dflt_wr  = wdata[PG_W-1:0];
                RA_WIN_LO:  r_d.win_lo   = wdata[PG_W-1:0];
                RA_WIN_SPN: r_d.win_span = wdata[PG_W-1:0];
                default: ;
            endcase
        end
        if (fault_set && !r_d.fs_v) begin
            r_d.fs_v   = 1'b1;
            r_d.fs_w   = fault_wr;
            r_d.fs_vpn = fault_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_VERSION: rdata = 32'(LAYOUT_ID) << 8;
            RA_CONFIG:  rdata = {27'd0, r_q.byp, 2'b00, r_q.gate, r_q.en};
            RA_FSTAT: begin
                rdata     = 32'(r_q.fs_vpn);
                rdata[31] = r_q.fs_v;
                rdata[30] = r_q.fs_w;
            end
            RA_TBASE:   rdata = 32'(r_q.tbase);
            RA_DFLT_RD: rdata = 32'(r_q.dflt_rd);
            RA_DFLT_WR: rdata = 32'(r_q.dflt_wr);
            RA_WIN_LO:  rdata = 32'(r_q.win_lo);
            RA_WIN_SPN: rdata = 32'(r_q.win_span);
            default:    rdata = '0;
        endcase
    end

    assign flush    = we && (addr == RA_FLUSH);
    assign xl_en    = r_q.en;
    assign xl_byp   = r_q.byp;
    assign tbase    = r_q.tbase;
    assign dflt_rd  = r_q.dflt_rd;
    assign dflt_wr  = r_q.dflt_wr;
    assign win_lo   = r_q.win_lo;
    assign win_span = r_q.win_span;

    // R10
    fstat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fs_v && !(we && addr == RA_FSTAT && wdata[31])) |=> (r_q.fs_v && $stable(r_q.fs_vpn)));

endmodule

// File: rtl/ftlb_cache.sv
module ftlb_cache #(
    parameter int N     = 4,
    parameter int TAG_W = 20,
    parameter int DAT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [DAT_W-1:0] hit_dat,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DAT_W-1:0] fill_dat
);

    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][DAT_W-1:0] dat;
        logic [PTR_W-1:0]        rr;
    } cache_t;

    cache_t       c_q, c_d;
    logic [N-1:0] match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = c_q.vld[g] && (c_q.tag[g] == look_tag);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        hit_dat = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_dat = hit_dat | c_q.dat[i];
        end
    end

    always_comb begin
        c_d = c_q;
        if (flush) begin
            c_d.vld = '0;
        end else if (fill) begin
            c_d.vld[c_q.rr] = 1'b1;
            c_d.tag[c_q.rr] = fill_tag;
            c_d.dat[c_q.rr] = fill_dat;
            c_d.rr = (c_q.rr == PTR_W'(N - 1)) ? '0 : c_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R8
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

// File: rtl/ftlb_iommu.sv
module ftlb_iommu
    import ftlb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int TLB_N      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);

    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    typedef struct packed {
        xl_state_e         st;
        logic [ADDR_W-1:0] va;
        logic              wr;
        logic [ADDR_W-1:0] pa;
        logic              flt;
        logic              drop;
        logic [ADDR_W-1:0] maddr;
    } xl_t;

    xl_t x_q, x_d;

    logic                  xl_en, xl_byp, flush, xl_on, accept, in_win;
    logic                  hit, fill, ent_zero, fault_set;
    logic [PG_W-1:0]       tbase, dflt_rd, dflt_wr, win_lo, win_span;
    logic [PG_W-1:0]       hit_ppn, req_vpn, rel;
    logic [PAGE_SHIFT-1:0] req_off, held_off;

    assign req_vpn  = req_va[ADDR_W-1:PAGE_SHIFT];
    assign req_off  = req_va[PAGE_SHIFT-1:0];
    assign held_off = x_q.va[PAGE_SHIFT-1:0];
    assign rel      = req_vpn - win_lo;
    assign in_win   = (req_vpn >= win_lo) && (rel <= win_span);
    assign xl_on    = xl_en && !xl_byp;
    assign accept   = req_valid && req_ready;
    assign ent_zero = (mem_rsp_data == '0);
    assign fill     = (x_q.st == ST_WAIT) && mem_rsp_valid && !ent_zero
                      && !x_q.drop && !flush;
    assign fault_set = (x_q.st == ST_RESP) && x_q.flt;

    ftlb_regs #(.PG_W(PG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .fault_set (fault_set),
        .fault_vpn (x_q.va[ADDR_W-1:PAGE_SHIFT]),
        .fault_wr  (x_q.wr),
        .xl_en     (xl_en),
        .xl_byp    (xl_byp),
        .flush     (flush),
        .tbase     (tbase),
        .dflt_rd   (dflt_rd),
        .dflt_wr   (dflt_wr),
        .win_lo    (win_lo),
        .win_span  (win_span)
    );

    ftlb_cache #(.N(TLB_N), .TAG_W(PG_W), .DAT_W(PG_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_tag (req_vpn),
        .hit      (hit),
        .hit_dat  (hit_ppn),
        .fill     (fill),
        .fill_tag (x_q.va[ADDR_W-1:PAGE_SHIFT]),
        .fill_dat (mem_rsp_data[PG_W-1:0])
    );

    always_comb begin
        x_d = x_q;
        if (flush && (x_q.st == ST_FETCH || x_q.st == ST_WAIT)) x_d.drop = 1'b1;
        case (x_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    x_d.va    = req_va;
                    x_d.wr    = req_write;
                    x_d.flt   = 1'b0;
                    x_d.drop  = 1'b0;
                    x_d.maddr = {tbase, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(rel) << 2);
                    x_d.st    = ST_RESP;
                    if (!xl_on) begin
                        x_d.pa = req_va;
                    end else if (!in_win) begin
                        x_d.pa  = {req_write ? dflt_wr : dflt_rd, req_off};
                        x_d.flt = 1'b1;
                    end else if (hit) begin
                        x_d.pa = {hit_ppn, req_off};
                    end else begin
                        x_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) x_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    x_d.st = ST_RESP;
                    if (ent_zero) begin
                        x_d.flt = 1'b1;
                        x_d.pa  = {x_q.wr ? dflt_wr : dflt_rd, held_off};
                    end else begin
                        x_d.pa = {mem_rsp_data[PG_W-1:0], held_off};
                    end
                end
            end
            ST_RESP: x_d.st = ST_IDLE;
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign req_ready     = (x_q.st == ST_IDLE);
    assign rsp_valid     = (x_q.st == ST_RESP);
    assign rsp_pa        = x_q.pa;
    assign rsp_fault     = x_q.flt;
    assign mem_req_valid = (x_q.st == ST_FETCH);
    assign mem_req_addr  = x_q.maddr;

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !xl_on) |=> (rsp_valid && !rsp_fault && rsp_pa == $past(req_va)));

    // R3
    window_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xl_on && !in_win) |=> (rsp_valid && rsp_fault && !mem_req_valid));

    // R7
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xl_on && in_win && hit) |=> (rsp_valid && !rsp_fault));

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: tb/tb_ftlb_iommu.sv
module tb_ftlb_iommu;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBASE_PPN = 32'h40;
    localparam logic [31:0] TBASE_B   = 32'h40000;
    localparam logic [19:0] WLO       = 20'h100;
    localparam logic [19:0] WSPAN     = 20'd15;
    localparam logic [19:0] DRD       = 20'h0AAAA;
    localparam logic [19:0] DWR       = 20'h0BBBB;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_va;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_pa;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int total = 0;
    int bad = 0;
    int fetch_cnt = 0;
    logic [31:0] cap_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftlb_iommu dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] ent(input int idx);
        if (idx % 5 == 3) return 32'h0;
        return 32'h30000 + 32'(idx) * 32'h111;
    endfunction

    function automatic logic [31:0] va_of(input int idx, input logic [11:0] off);
        return {WLO + 20'(idx), off};
    endfunction

    // memory: one wait cycle before accepting, data on the following cycle
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ent(int'((cap_addr - TBASE_B) >> 2));
            end else if (mem_req_valid) begin
                mem_req_ready = 1'b1;
                cap_addr      = mem_req_addr;
                fetch_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic xreq(input logic [31:0] va, input logic wr,
                        output logic [31:0] pa, output logic flt, output int lat);
        int rdy_hi = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) rdy_hi++;
            @(negedge clk);
            lat++;
        end
        if (req_ready) rdy_hi++;
        pa  = rsp_pa;
        flt = rsp_fault;
        chk("R11 ready while busy", 32'(rdy_hi), 32'd0);
    endtask

    task automatic xp(input string tag, input logic [31:0] va, input logic wr,
                      input logic [31:0] epa, input logic eflt, input int elat, input int efetch);
        int f0 = fetch_cnt;
        logic [31:0] pa;
        logic flt;
        int lat;
        xreq(va, wr, pa, flt, lat);
        chk({tag, " pa"}, pa, epa);
        chk({tag, " fault"}, 32'(flt), 32'(eflt));
        chk({tag, " latency"}, 32'(lat), 32'(elat));
        chk({tag, " fetches"}, 32'(fetch_cnt - f0), 32'(efetch));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [11:0] off;
        logic [31:0] pa;
        logic flt;
        int lat;
        int f0;

        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_va = '0; req_write = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R4 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
        rd_reg(6'h00, d); chk("R1 version", d, 32'h0000_0100);
        rd_reg(6'h0C, d); chk("R1 fault status reset", d, 32'h0);
        rd_reg(6'h04, d); chk("R12 control reset", d, 32'h0);

        // R12 readback mask
        wr_reg(6'h04, 32'hFFFF_FFFF);
        rd_reg(6'h04, d); chk("R12 control mask", d, 32'h13);
        wr_reg(6'h04, 32'h0);

        // R2 pass-through with enable clear
        for (int i = 0; i < 8; i++) begin
            d = 32'(i) * 32'h1357_9BDF ^ 32'hA5A5_0000;
            xp("R2 disabled", d, i[0], d, 1'b0, 1, 0);
        end
        wr_reg(6'h04, 32'h2);   // gate only: still pass-through
        xp("R12 gate-only", 32'h0010_0123, 1'b0, 32'h0010_0123, 1'b0, 1, 0);

        // program window and fallback pages
        wr_reg(6'h10, TBASE_PPN);
        wr_reg(6'h14, 32'(DRD));
        wr_reg(6'h18, 32'(DWR));
        wr_reg(6'h1C, 32'(WLO));
        wr_reg(6'h20, 32'(WSPAN));
        rd_reg(6'h20, d); chk("R12 span readback", d, 32'(WSPAN));

        // R2 bypass with enable set
        wr_reg(6'h04, 32'h13);
        for (int i = 0; i < 4; i++)
            xp("R2 bypass", va_of(i, 12'h321), 1'b1, va_of(i, 12'h321), 1'b0, 1, 0);

        wr_reg(6'h04, 32'h3);
        wr_reg(6'h08, 32'h0);

        // R4/R5/R6 sweep every page of the window
        for (int i = 0; i < 16; i++) begin
            off = 12'((i * 37 + 5) & 12'hFFF);
            if (ent(i) == 0)
                xp("R6 zero entry", va_of(i, off), 1'b0, {DRD, off}, 1'b1, 3, 1);
            else
                xp("R5 table hit", va_of(i, off), 1'b0, {ent(i)[19:0], off}, 1'b0, 3, 1);
            chk("R4 table address", cap_addr, TBASE_B + 32'(i) * 4);
        end
        rd_reg(6'h0C, d); chk("R10 first fault", d, 32'h8000_0103);

        // R7 cached pages 11,12,14,15
        xp("R7 hit write", va_of(15, 12'hABC), 1'b1, {ent(15)[19:0], 12'hABC}, 1'b0, 1, 0);
        xp("R7 hit read", va_of(11, 12'h001), 1'b0, {ent(11)[19:0], 12'h001}, 1'b0, 1, 0);

        // R6 zero entry never cached, write direction
        xp("R6 zero write", va_of(13, 12'h044), 1'b1, {DWR, 12'h044}, 1'b1, 3, 1);
        xp("R6 zero refetch", va_of(13, 12'h045), 1'b1, {DWR, 12'h045}, 1'b1, 3, 1);

        // R3 window edges
        xp("R3 below", {WLO - 20'd1, 12'h010}, 1'b0, {DRD, 12'h010}, 1'b1, 1, 0);
        xp("R3 above", {WLO + WSPAN + 20'd1, 12'h020}, 1'b1, {DWR, 12'h020}, 1'b1, 1, 0);
        xp("R3 last page", va_of(15, 12'hFFF), 1'b0, {ent(15)[19:0], 12'hFFF}, 1'b0, 1, 0);
        xp("R3 vpn zero", 32'h0000_0777, 1'b0, {DRD, 12'h777}, 1'b1, 1, 0);
        xp("R3 vpn max", 32'hFFFF_F888, 1'b1, {DWR, 12'h888}, 1'b1, 1, 0);

        // R8 round-robin replacement
        wr_reg(6'h08, 32'h1234_5678);
        xp("R8 fill0", va_of(0, 12'h0), 1'b0, {ent(0)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 fill1", va_of(1, 12'h0), 1'b0, {ent(1)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 fill2", va_of(2, 12'h0), 1'b0, {ent(2)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 fill3", va_of(4, 12'h0), 1'b0, {ent(4)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 resident", va_of(0, 12'h9), 1'b0, {ent(0)[19:0], 12'h9}, 1'b0, 1, 0);
        xp("R8 evict oldest", va_of(5, 12'h0), 1'b0, {ent(5)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 second kept", va_of(1, 12'h0), 1'b0, {ent(1)[19:0], 12'h0}, 1'b0, 1, 0);
        xp("R8 first gone", va_of(0, 12'h0), 1'b0, {ent(0)[19:0], 12'h0}, 1'b0, 3, 1);
        xp("R8 second evicted", va_of(1, 12'h0), 1'b0, {ent(1)[19:0], 12'h0}, 1'b0, 3, 1);

        // R9 flush
        xp("R9 before flush", va_of(4, 12'h5), 1'b0, {ent(4)[19:0], 12'h5}, 1'b0, 1, 0);
        wr_reg(6'h08, 32'h0);
        xp("R9 after flush", va_of(4, 12'h5), 1'b0, {ent(4)[19:0], 12'h5}, 1'b0, 3, 1);

        // R9 flush while a table read is in flight
        f0 = fetch_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_va = va_of(6, 12'h66); req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 6'h08; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
        chk("R9 in-flight pa", rsp_pa, {ent(6)[19:0], 12'h66});
        chk("R9 in-flight fetch", 32'(fetch_cnt - f0), 32'd1);
        xp("R9 dropped fill", va_of(6, 12'h67), 1'b0, {ent(6)[19:0], 12'h67}, 1'b0, 3, 1);
        xp("R9 refill kept", va_of(6, 12'h68), 1'b0, {ent(6)[19:0], 12'h68}, 1'b0, 1, 0);

        // R10 fault status
        wr_reg(6'h0C, 32'h8000_0000);
        rd_reg(6'h0C, d); chk("R10 cleared", d, 32'h0);
        xp("R10 write fault", 32'h0012_0AAA, 1'b1, {DWR, 12'hAAA}, 1'b1, 1, 0);
        rd_reg(6'h0C, d); chk("R10 capture", d, 32'hC000_0120);
        xp("R10 second fault", 32'h000F_F001, 1'b0, {DRD, 12'h001}, 1'b1, 1, 0);
        rd_reg(6'h0C, d); chk("R10 first kept", d, 32'hC000_0120);
        wr_reg(6'h0C, 32'h7FFF_FFFF);
        rd_reg(6'h0C, d); chk("R10 no clear", d, 32'hC000_0120);
        wr_reg(6'h0C, 32'h8000_0000);
        rd_reg(6'h0C, d); chk("R10 clear", d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule